// File: doc/BRIEF.md
# Programmable Edge/Level Interrupt Controller

This block gathers fourteen interrupt request lines from the peripherals of a chip and merges them into a single interrupt output for a processor. Software programs each line through four word-wide registers. For each line it can choose between edge-triggered and level-sensitive capture, choose which edge or level counts as active, and switch the line off. It can also read the set of pending lines and clear pending bits by writing ones.

The request inputs come from other clock domains. Each one passes through a two-flop synchronizer before any capture logic sees it. The block does not rank the lines and supplies no vector. An interrupt handler reads the pending word to find the source, services it, and writes the matching bit back to clear it.

The line order is buffer manager (bit 0), one-shot timer, SPI, I2C, PHY, underrun, overrun, pulse-per-second, UART receive, UART transmit, serial link, clock status, periodic timer, and push button (bit 13). Every register uses the same bit-per-line layout.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, register 0 (edge select) reads 0, register 1 (polarity) reads 0x3FFF (all lines active high), register 2 (disable) reads 0, register 3 (pending) reads 0, and `irq` is low.
- R2: A write to register 0, 1 or 2 (selected by `addr`) stores bits 13:0 of `wdata` and is visible on `rdata` in the next cycle. Bits 31:14 of `rdata` always read zero.
- R3: A change on `req_in[i]` reaches the capture logic through two synchronizer flops. For a level line, the pending bit changes after the third rising clock edge that follows the input change.
- R4: For a line whose edge-select bit is 0, pending bit i follows the polarity-adjusted synchronized input. Writing a 1 to register 3 has no lasting effect on that bit while the input stays active.
- R5: For a line whose edge-select bit is 1, the active edge on the synchronized input sets pending bit i. The bit stays set until a write to register 3 carries a 1 in bit i. Zeros written to register 3 leave pending bits unchanged.
- R6: When an active edge and a clearing write to register 3 reach an edge line in the same cycle, the pending bit ends up set.
- R7: Polarity bit 1 makes the rising edge (or high level) active. Polarity bit 0 makes the falling edge (or low level) active.
- R8: `irq` is high exactly when some line is pending and its disable bit is 0. A disabled line still shows its pending bit in register 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 14 | Asynchronous interrupt request lines, bit i is line i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 edge select, 1 polarity, 2 disable, 3 pending |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register selected by `addr` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Directed sequences use a single level line to measure the three-cycle input latency, and to show that a clear write cannot override a level that is still active. A one-cycle pulse on an edge line shows that the bit stays pending after the input returns, and that zero writes leave it alone. An active-low line separates the falling edge from the rising edge. A pulse timed so that its edge meets a clear write in the same cycle shows which of the two wins. A long phase with random request words and random register writes is compared every clock against a behavioural model. This phase mixes modes, polarity flips and disables, and checks that `irq` tracks only pending lines that are enabled.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_LINES = 14,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irq
);

  localparam logic [1:0] A_TRIG = 2'd0;
  localparam logic [1:0] A_POL  = 2'd1;
  localparam logic [1:0] A_DIS  = 2'd2;
  localparam logic [1:0] A_PEND = 2'd3;

  logic [NUM_LINES-1:0] sync1, sync2;
  logic [NUM_LINES-1:0] trig_q, pol_q, dis_q, pend_q;
  logic [NUM_LINES-1:0] act, act_d, rise, clr_w, wfield;

  assign wfield = wdata[NUM_LINES-1:0];
  assign act    = ~(sync2 ^ pol_q);
  assign rise   = act & ~act_d;
  assign clr_w  = (wr_en && addr == A_PEND) ? wfield : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      act_d  <= '0;
      pend_q <= '0;
      trig_q <= '0;
      pol_q  <= '1;
      dis_q  <= '0;
    end else begin
      sync1  <= req_in;
      sync2  <= sync1;
      act_d  <= act;
      pend_q <= (trig_q & (rise | (pend_q & ~clr_w))) | (~trig_q & act);
      if (wr_en) begin
        case (addr)
          A_TRIG:  trig_q <= wfield;
          A_POL:   pol_q  <= wfield;
          A_DIS:   dis_q  <= wfield;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_TRIG:  rdata = DATA_W'(trig_q);
      A_POL:   rdata = DATA_W'(pol_q);
      A_DIS:   rdata = DATA_W'(dis_q);
      default: rdata = DATA_W'(pend_q);
    endcase
  end

  assign irq = |(pend_q & ~dis_q);

  // R3
  sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync2 == $past(sync1));

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(trig_q) & (pend_q ^ $past(act))) == '0));

  // R5
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(trig_q & pend_q & ~clr_w) & ~pend_q) == '0));

  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(trig_q & rise & clr_w) & ~pend_q) == '0));

  // R8
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&dis_q) |-> !irq);

endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  localparam int N = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_in = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = 2'd3;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic [N-1:0] hist[$] = '{'0, '0};
  bit m_edge[N], m_pol[N], m_dis[N], m_pend[N], m_prev[N];

  task automatic model_reset();
    hist = '{'0, '0};
    for (int i = 0; i < N; i++) begin
      m_edge[i] = 0; m_pol[i] = 1; m_dis[i] = 0; m_pend[i] = 0; m_prev[i] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic [N-1:0] seen;
      seen = hist.pop_front();
      hist.push_back(req_in);
      for (int i = 0; i < N; i++) begin
        bit a;
        bit clr;
        a   = m_pol[i] ? seen[i] : !seen[i];
        clr = wr_en && addr == 2'd3 && wdata[i];
        if (m_edge[i]) m_pend[i] = (a && !m_prev[i]) || (m_pend[i] && !clr);
        else           m_pend[i] = a;
        m_prev[i] = a;
      end
      if (wr_en)
        for (int i = 0; i < N; i++) begin
          if (addr == 2'd0) m_edge[i] = wdata[i];
          if (addr == 2'd1) m_pol[i]  = wdata[i];
          if (addr == 2'd2) m_dis[i]  = wdata[i];
        end
    end
  end

  function automatic logic [31:0] model_read(logic [1:0] a);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < N; i++)
      case (a)
        2'd0: v[i] = m_edge[i];
        2'd1: v[i] = m_pol[i];
        2'd2: v[i] = m_dis[i];
        default: v[i] = m_pend[i];
      endcase
    return v;
  endfunction

  function automatic logic model_irq();
    logic r;
    r = 0;
    for (int i = 0; i < N; i++) r |= m_pend[i] && !m_dis[i];
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk += 2;
      if (irq !== model_irq()) begin
        n_bad++;
        $display("FAIL R8 model irq: actual %0b expected %0b", irq, model_irq());
      end
      if (rdata !== model_read(addr)) begin
        n_bad++;
        $display("FAIL %s model reg%0d: actual %h expected %h",
                 (addr == 2'd3) ? "R5" : "R2", addr, rdata, model_read(addr));
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; addr = 2'd3; wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    addr = a;
    @(negedge clk);
    chk(req, rdata, exp);
    tick();
    addr = 2'd3;
  endtask

  task automatic pend_chk(string req, logic [31:0] exp);
    addr = 2'd3;
    @(negedge clk);
    chk(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R1 reset state
    rd_chk("R1", 2'd0, 32'h0);
    rd_chk("R1", 2'd1, 32'h3FFF);
    rd_chk("R1", 2'd2, 32'h0);
    rd_chk("R1", 2'd3, 32'h0);
    @(negedge clk); chk("R1 irq", {31'b0, irq}, 32'h0);
    tick();

    // R2 register storage
    wr(2'd2, 32'hFFFF_FFFF);
    rd_chk("R2", 2'd2, 32'h3FFF);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'hA000_1234);
    rd_chk("R2", 2'd0, 32'h1234);
    wr(2'd0, 32'h0);

    // R3 latency, line 2 level active high
    req_in[2] = 1'b1;
    tick(); tick();
    pend_chk("R3 before", 32'h0);
    tick();
    pend_chk("R3 after", 32'h4);
    @(negedge clk); chk("R8 irq", {31'b0, irq}, 32'h1);
    tick();

    // R4 clear has no lasting effect on active level
    wr(2'd3, 32'h4);
    pend_chk("R4 hold", 32'h4);
    tick();
    req_in[2] = 1'b0;
    repeat (3) tick();
    pend_chk("R4 drop", 32'h0);
    tick();

    // R5 edge line 5, one-cycle pulse
    wr(2'd0, 32'h20);
    req_in[5] = 1'b1; tick(); req_in[5] = 1'b0;
    repeat (5) tick();
    pend_chk("R5 set", 32'h20);
    tick();
    wr(2'd3, 32'h0);
    pend_chk("R5 zero write", 32'h20);
    tick();
    wr(2'd3, 32'h20);
    pend_chk("R5 cleared", 32'h0);
    tick();

    // R6 edge and clear in the same cycle
    req_in[5] = 1'b1;
    tick(); tick();
    wr_en = 1'b1; addr = 2'd3; wdata = 32'h20;
    tick();
    wr_en = 1'b0; wdata = '0;
    pend_chk("R6", 32'h20);
    tick();
    req_in[5] = 1'b0;
    repeat (4) tick();
    wr(2'd3, 32'h20);

    // R7 line 7 active low
    req_in[7] = 1'b1;
    wr(2'd1, 32'h3F7F);
    repeat (4) tick();
    pend_chk("R7 high idle", 32'h0);
    tick();
    wr(2'd0, 32'hA0);
    req_in[7] = 1'b0;
    repeat (4) tick();
    pend_chk("R7 falling", 32'h80);
    tick();
    wr(2'd3, 32'h80);
    req_in[7] = 1'b1;
    repeat (4) tick();
    pend_chk("R7 rising ignored", 32'h0);
    tick();

    // R8 disable hides irq but not pending
    req_in[7] = 1'b0;
    repeat (4) tick();
    wr(2'd2, 32'h80);
    pend_chk("R8 pend visible", 32'h80);
    @(negedge clk); chk("R8 masked", {31'b0, irq}, 32'h0);
    tick();
    wr(2'd2, 32'h0);
    @(negedge clk); chk("R8 unmasked", {31'b0, irq}, 32'h1);
    tick();

    // random phase compared against the model each clock
    for (int k = 0; k < 600; k++) begin
      req_in = N'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1; addr = 2'($urandom); wdata = $urandom;
      end else begin
        wr_en = 1'b0; addr = 2'($urandom); wdata = '0;
      end
      tick();
    end
    wr_en = 1'b0;
    tick();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule